// File: doc/BRIEF.md
# NAND Flash Host Port Front End

This block sits between a simple register bus and an 8-bit NAND flash port. Software queues command bytes, address bytes, data bytes and single-byte read requests into one shared four-entry buffer. A strobe sequencer drains the buffer in order. It drives the latch-enable lines and the active-low write or read strobe for each entry. Each strobe width comes from a programmable delay in the control register.

A read is launched by writing any value to the read-request register. The sequencer waits until the synchronized ready/busy pin shows the device ready. It then pulses the read strobe and captures the data bus at the end of the pulse. It sets a sticky ready flag, and the captured byte is readable from the read-data register. A status register reports the buffer and device state. A write-one-to-clear interrupt status register and a mask register combine into one interrupt output.

The sequencer has three states. S_IDLE waits for a buffer entry. If the head entry is a read and the device is busy, it holds in S_IDLE. Otherwise the launch transition moves it to S_STROBE. S_STROBE counts down the delay and then takes the count-done transition to S_GAP. S_GAP is one idle clock. From S_GAP the relaunch transition goes straight back to S_STROBE if another entry can start, and the return-idle transition goes to S_IDLE if not.

Top module: `nand_host_if`

## Requirements
- R1: After reset the interrupt status register (address 2) reads 0 and the interrupt output is low. The write and read strobes are high, both latch enables are low, status bit 4 (buffer empty) reads 1 and status bit 1 (buffer full) reads 0.
- R2: The control register at address 0 keeps bits [9:0] of a write and reads them back. Higher bits read 0. Bits [3:0] are the write-strobe delay and bits [7:4] are the read-strobe delay.
- R3: A byte written to address 6 (data) is driven on the flash data bus with the write strobe low for write-delay + 1 clocks, with both latch enables low.
- R4: A byte written to address 4 (command) is sent with the command latch enable high during its write strobe. A byte written to address 5 (address) is sent with the address latch enable high during its write strobe.
- R5: Any write to address 7 launches a one-byte read. The read strobe is low for read-delay + 1 clocks, and the data bus is captured at the end of the pulse. The captured byte then reads from address 8 and interrupt status bit 3 is set.
- R6: Consecutive buffer entries leave the buffer in order, and exactly one high clock separates their strobes.
- R7: A read entry does not start while the ready/busy pin, after a two-flop synchronizer, is low. Status bit 3 (read pending) stays 1 from the request until the byte is captured.
- R8: The buffer holds 4 entries. A command, address, data or read-request write while it is full is dropped and sets interrupt status bit 1.
- R9: The status register (address 1) reports bit0 = synchronized ready, bit1 = buffer full, bit2 = write pending (buffer not empty or write strobe active), bit3 = read pending, bit4 = buffer empty.
- R10: Writing 1s to address 2 clears those interrupt status bits and leaves the others. A flag event in the same cycle wins over the clear.
- R11: Interrupt status bit 0 is set on a rising edge of the synchronized ready. Bit 2 is set when the buffer stops being full. Bit 4 is set when a write strobe finishes with the buffer empty.
- R12: The interrupt output is the OR of the interrupt status bits ANDed with the mask register at address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| irq | output | 1 | Masked interrupt |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_doe | output | 1 | Data bus output enable |
| nf_dout | output | 8 | Data bus out |
| nf_din | input | 8 | Data bus in |
| nf_rdy | input | 1 | Device ready (high) / busy (low) |

## Verification
A register write into the buffer and the sequencer's pop can land on the same clock edge. The buffer must then keep its count without losing or repeating an entry. The bench provokes this by writing bytes on consecutive cycles while the first entry is launching, and by filling the buffer behind a long strobe. It judges the result by watching that every accepted byte appears on the data bus in order, that the expected number of strobes occurs, and that exactly the writes beyond the depth are dropped and flagged.

// File: rtl/nand_host_pkg.sv
`timescale 1ns/1ps
package nand_host_pkg;
    typedef enum logic [1:0] {
        E_CMD  = 2'd0,
        E_ADDR = 2'd1,
        E_DATA = 2'd2,
        E_READ = 2'd3
    } entry_kind_e;

    typedef struct packed {
        entry_kind_e kind;
        logic [7:0]  byte_v;
    } bus_entry_t;

    localparam logic [3:0] A_CTRL   = 4'h0;
    localparam logic [3:0] A_STAT   = 4'h1;
    localparam logic [3:0] A_IRQ    = 4'h2;
    localparam logic [3:0] A_MASK   = 4'h3;
    localparam logic [3:0] A_CMD    = 4'h4;
    localparam logic [3:0] A_ADDR   = 4'h5;
    localparam logic [3:0] A_DATA   = 4'h6;
    localparam logic [3:0] A_RDREQ  = 4'h7;
    localparam logic [3:0] A_RDDATA = 4'h8;

    localparam int CTRL_W = 10;
    localparam int FLAG_W = 5;
    localparam int DLY_W  = 4;
endpackage

// File: rtl/nand_wbuf.sv
`timescale 1ns/1ps
module nand_wbuf #(
    parameter int DEPTH = 4,
    parameter int W     = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;
    logic          push_ok, pop_ok;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
            if (pop_ok)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
            if (push_ok && !pop_ok)      cnt <= cnt + CW'(1);
            else if (pop_ok && !push_ok) cnt <= cnt - CW'(1);
        end
    end

    // R6: the sequencer never takes an entry from an empty buffer
    a_r6_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    // R8: a write into a full buffer without a pop leaves it full (dropped)
    a_r8_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full);
endmodule

// File: rtl/nand_strobe_seq.sv
`timescale 1ns/1ps
module nand_strobe_seq
    import nand_host_pkg::*;
#(
    parameter int CNT_W = DLY_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bus_entry_t       head,
    input  logic             head_valid,
    input  logic             rdy_i,
    input  logic [CNT_W-1:0] wr_dly,
    input  logic [CNT_W-1:0] rd_dly,
    input  logic [7:0]       nf_din,
    output logic             pop,
    output logic             nf_cle,
    output logic             nf_ale,
    output logic             nf_we_n,
    output logic             nf_re_n,
    output logic             nf_doe,
    output logic [7:0]       nf_dout,
    output logic             rd_done,
    output logic             wr_done,
    output logic             wr_active,
    output logic [7:0]       rd_byte
);
    typedef enum logic [1:0] {S_IDLE, S_STROBE, S_GAP} seq_state_e;

    seq_state_e       state, state_nx;
    bus_entry_t       cur;
    logic [CNT_W-1:0] cnt;
    logic             launch, finish, strobing, cur_rd;

    assign launch = head_valid && ((head.kind != E_READ) || rdy_i)
                    && ((state == S_IDLE) || (state == S_GAP));
    assign pop    = launch;
    assign finish = (state == S_STROBE) && (cnt == '0);
    assign cur_rd = (cur.kind == E_READ);

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   state_nx = launch ? S_STROBE : S_IDLE;
            S_STROBE: state_nx = (cnt == '0) ? S_GAP : S_STROBE;
            S_GAP:    state_nx = launch ? S_STROBE : S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur     <= '{kind: E_DATA, byte_v: 8'h00};
            cnt     <= '0;
            rd_byte <= '0;
        end else begin
            if (launch) begin
                cur <= head;
                cnt <= (head.kind == E_READ) ? rd_dly : wr_dly;
            end else if ((state == S_STROBE) && (cnt != '0)) begin
                cnt <= cnt - CNT_W'(1);
            end
            if (finish && cur_rd) rd_byte <= nf_din;
        end
    end

    always_comb begin
        strobing  = (state == S_STROBE);
        nf_cle    = strobing && (cur.kind == E_CMD);
        nf_ale    = strobing && (cur.kind == E_ADDR);
        nf_we_n   = !(strobing && !cur_rd);
        nf_re_n   = !(strobing && cur_rd);
        nf_doe    = strobing && !cur_rd;
        nf_dout   = cur.byte_v;
        wr_active = strobing && !cur_rd;
        rd_done   = finish && cur_rd;
        wr_done   = finish && !cur_rd;
    end

    // R6: the idle clock always follows a strobe
    a_r6_gap_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_GAP) |-> ($past(state) == S_STROBE));
    // R7: a read strobe only begins after the device was seen ready
    a_r7_read_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nf_re_n) |-> $past(rdy_i));
    // R3: write and read strobes never overlap
    a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nf_we_n && !nf_re_n));
    // R4: command and address latch enables are exclusive
    a_r4_latch_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(nf_cle && nf_ale));
endmodule

// File: rtl/nand_host_if.sv
`timescale 1ns/1ps
module nand_host_if
    import nand_host_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int FIFO_DEPTH  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [3:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic              nf_cle,
    output logic              nf_ale,
    output logic              nf_we_n,
    output logic              nf_re_n,
    output logic              nf_doe,
    output logic [7:0]        nf_dout,
    input  logic [7:0]        nf_din,
    input  logic              nf_rdy
);
    localparam int EW  = $bits(bus_entry_t);
    localparam int RCW = $clog2(FIFO_DEPTH + 2);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   rdy_s, rdy_prev, full_prev;
    logic [CTRL_W-1:0]      ctrl_q;
    logic [FLAG_W-1:0]      mask_q, irq_q, irq_ev, irq_clr, stat;
    logic [RCW-1:0]         rd_cnt;
    bus_entry_t             fifo_in, fifo_out;
    logic                   fifo_wr, fifo_full, fifo_empty, fifo_pop;
    logic                   rd_done, wr_done, wr_active, rd_accept;
    logic [7:0]             rd_byte;
    logic                   unused_wbits;

    assign unused_wbits = ^reg_wdata[DATA_W-1:CTRL_W];
    assign rdy_s        = sync_q[SYNC_STAGES-1];

    always_comb begin
        fifo_wr      = 1'b0;
        fifo_in.kind = E_DATA;
        unique case (reg_addr)
            A_CMD:   begin fifo_wr = reg_wr; fifo_in.kind = E_CMD;  end
            A_ADDR:  begin fifo_wr = reg_wr; fifo_in.kind = E_ADDR; end
            A_DATA:  begin fifo_wr = reg_wr; fifo_in.kind = E_DATA; end
            A_RDREQ: begin fifo_wr = reg_wr; fifo_in.kind = E_READ; end
            default: ;
        endcase
        fifo_in.byte_v = reg_wdata[7:0];
    end

    assign rd_accept = fifo_wr && !fifo_full && (fifo_in.kind == E_READ);

    nand_wbuf #(.DEPTH(FIFO_DEPTH), .W(EW)) i_wbuf (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fifo_wr),
        .din   (fifo_in),
        .pop   (fifo_pop),
        .dout  (fifo_out),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    nand_strobe_seq i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .head       (fifo_out),
        .head_valid (!fifo_empty),
        .rdy_i      (rdy_s),
        .wr_dly     (ctrl_q[3:0]),
        .rd_dly     (ctrl_q[7:4]),
        .nf_din     (nf_din),
        .pop        (fifo_pop),
        .nf_cle     (nf_cle),
        .nf_ale     (nf_ale),
        .nf_we_n    (nf_we_n),
        .nf_re_n    (nf_re_n),
        .nf_doe     (nf_doe),
        .nf_dout    (nf_dout),
        .rd_done    (rd_done),
        .wr_done    (wr_done),
        .wr_active  (wr_active),
        .rd_byte    (rd_byte)
    );

    always_comb begin
        irq_ev[0] = rdy_s && !rdy_prev;
        irq_ev[1] = fifo_wr && fifo_full;
        irq_ev[2] = full_prev && !fifo_full;
        irq_ev[3] = rd_done;
        irq_ev[4] = wr_done && fifo_empty;
        irq_clr   = (reg_wr && (reg_addr == A_IRQ)) ? reg_wdata[FLAG_W-1:0] : '0;
        stat      = {fifo_empty, (rd_cnt != '0), (!fifo_empty || wr_active),
                     fifo_full, rdy_s};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q    <= '0;
            rdy_prev  <= 1'b0;
            full_prev <= 1'b0;
            ctrl_q    <= '0;
            mask_q    <= '0;
            irq_q     <= '0;
            rd_cnt    <= '0;
        end else begin
            sync_q    <= {sync_q[SYNC_STAGES-2:0], nf_rdy};
            rdy_prev  <= rdy_s;
            full_prev <= fifo_full;
            irq_q     <= (irq_q & ~irq_clr) | irq_ev;
            if (reg_wr && (reg_addr == A_CTRL)) ctrl_q <= reg_wdata[CTRL_W-1:0];
            if (reg_wr && (reg_addr == A_MASK)) mask_q <= reg_wdata[FLAG_W-1:0];
            if (rd_accept && !rd_done)      rd_cnt <= rd_cnt + RCW'(1);
            else if (rd_done && !rd_accept) rd_cnt <= rd_cnt - RCW'(1);
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL:   reg_rdata = DATA_W'(ctrl_q);
            A_STAT:   reg_rdata = DATA_W'(stat);
            A_IRQ:    reg_rdata = DATA_W'(irq_q);
            A_MASK:   reg_rdata = DATA_W'(mask_q);
            A_RDDATA: reg_rdata = DATA_W'(rd_byte);
            default:  reg_rdata = '0;
        endcase
    end

    assign irq = |(irq_q & mask_q);

    // R8: a buffer write while full raises the overflow flag
    a_r8_no_overflow_loss: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr && fifo_full) |=> irq_q[1]);
    // R5: a finished read leaves the ready flag set
    a_r5_ready_flag: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> irq_q[3]);
    // R10: a W1C of the ready flag with no new read clears it
    a_r10_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == A_IRQ) && reg_wdata[3] && !rd_done) |=> !irq_q[3]);
endmodule

// File: tb/test_nand_host_if.sv
`timescale 1ns/1ps
module test_nand_host_if;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        irq, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_doe;
    logic [7:0]  nf_dout;
    logic [7:0]  nf_din = 8'h00;
    logic        nf_rdy = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    nand_host_if i_nand_host_if (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
        .nf_doe(nf_doe), .nf_dout(nf_dout), .nf_din(nf_din), .nf_rdy(nf_rdy)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // waits for the chosen strobe to go low, then counts its low clocks
    task automatic strobe(input bit use_re, output int width, output logic [7:0] d,
                          output logic c, output logic a);
        int t = 0;
        @(negedge clk);
        while ((use_re ? nf_re_n : nf_we_n) && t < 400) begin
            @(negedge clk); t++;
        end
        d = nf_dout; c = nf_cle; a = nf_ale;
        width = 0;
        while (!(use_re ? nf_re_n : nf_we_n) && width < 100) begin
            width++; @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int w, g;
        logic [7:0] d;
        logic c, a;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(nf_we_n && nf_re_n, "R1 strobes idle", {nf_we_n, nf_re_n}, 3);
        chk(!nf_cle && !nf_ale, "R1 latches low", {nf_cle, nf_ale}, 0);
        chk(irq == 1'b0, "R1 irq low", irq, 0);
        rd_reg(4'h2, v); chk(v == 16'h0, "R1 irq status", v, 0);
        rd_reg(4'h1, v); chk(v[4] && !v[1], "R1 status empty", v, 16'h10);

        // R2 control readback
        wr_reg(4'h0, 16'hFFFF); rd_reg(4'h0, v);
        chk(v == 16'h03FF, "R2 ctrl readback", v, 16'h03FF);

        // R3 write strobe width sweep
        for (int wd = 0; wd < 16; wd++) begin
            logic [7:0] b;
            b = 8'(wd * 13 + 7);
            wr_reg(4'h0, 16'(wd | (3 << 4)));
            wr_reg(4'h6, {8'h0, b});
            strobe(1'b0, w, d, c, a);
            chk(w == wd + 1, "R3 write width", w, wd + 1);
            chk(d == b, "R3 data byte", d, b);
            chk(!c && !a, "R3 latches low", {c, a}, 0);
            idle(3);
        end

        // R4 command and address latches
        wr_reg(4'h0, 16'h0002);
        wr_reg(4'h4, 16'h0070);
        strobe(1'b0, w, d, c, a);
        chk(c && !a && d == 8'h70, "R4 command latch", {c, a, d}, {2'b10, 8'h70});
        wr_reg(4'h5, 16'h0005);
        strobe(1'b0, w, d, c, a);
        chk(!c && a && d == 8'h05, "R4 address latch", {c, a, d}, {2'b01, 8'h05});

        // R6 gap between back-to-back entries (push and pop collide)
        idle(4);
        wr_reg(4'h0, 16'h0001);
        wr_reg(4'h6, 16'h00A1);
        wr_reg(4'h6, 16'h00A2);
        strobe(1'b0, w, d, c, a);
        chk(d == 8'hA1 && w == 2, "R6 first entry", {d, 8'(w)}, {8'hA1, 8'd2});
        g = 0;
        while (nf_we_n && g < 50) begin g++; @(negedge clk); end
        chk(g == 1, "R6 one idle clock", g, 1);
        d = nf_dout;
        chk(d == 8'hA2, "R6 order", d, 8'hA2);
        idle(6);

        // R7 read waits for ready
        wr_reg(4'h2, 16'hFFFF);
        wr_reg(4'h0, 16'h0000);
        wr_reg(4'h7, 16'h1234);
        g = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (!nf_re_n) g++; end
        chk(g == 0, "R7 no read while busy", g, 0);
        rd_reg(4'h1, v);
        chk(v[3] == 1'b1 && v[0] == 1'b0, "R7/R9 read pending busy", v[4:0], 5'h08);
        nf_din = 8'h5C; nf_rdy = 1'b1;
        strobe(1'b1, w, d, c, a);
        chk(w == 1, "R5 read width delay 0", w, 1);
        idle(3);
        rd_reg(4'h8, v); chk(v == 16'h005C, "R5 read data", v, 16'h5C);
        rd_reg(4'h2, v); chk(v[3] && v[0], "R5/R11 ready and not-busy flags", v, 16'h09);
        rd_reg(4'h1, v); chk(v[3] == 1'b0 && v[0], "R9 read no longer pending", v[4:0], 5'h11);

        // R5 read strobe width sweep
        for (int rd = 0; rd < 16; rd++) begin
            logic [7:0] b;
            b = 8'(rd * 11 + 3);
            wr_reg(4'h0, 16'(rd << 4));
            wr_reg(4'h2, 16'h0008);
            nf_din = b;
            wr_reg(4'h7, 16'h0000);
            strobe(1'b1, w, d, c, a);
            chk(w == rd + 1, "R5 read width", w, rd + 1);
            idle(3);
            rd_reg(4'h8, v); chk(v[7:0] == b, "R5 captured byte", v, b);
            rd_reg(4'h2, v); chk(v[3], "R5 ready flag", v, 16'h08);
        end

        // R8 overflow, R9 status, R11 events
        wr_reg(4'h2, 16'hFFFF);
        wr_reg(4'h0, 16'h000F);
        for (int k = 0; k < 8; k++) wr_reg(4'h6, 16'(8'h10 + k));
        rd_reg(4'h1, v);
        chk(v[4:0] == 5'b00111, "R9 status full", v[4:0], 5'b00111);
        chk(nf_dout == 8'h10 && !nf_we_n, "R8 first entry on bus", nf_dout, 8'h10);
        rd_reg(4'h2, v); chk(v[1], "R8 overflow flag", v, 16'h02);
        while (!nf_we_n) @(negedge clk);
        for (int k = 1; k < 5; k++) begin
            strobe(1'b0, w, d, c, a);
            chk(d == 8'(8'h10 + k), "R8 kept entry order", d, 8'h10 + k);
            chk(w == 16, "R3 width delay 15", w, 16);
        end
        g = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); if (!nf_we_n) g++; end
        chk(g == 0, "R8 dropped bytes not sent", g, 0);
        rd_reg(4'h2, v);
        chk(v[4:0] == 5'h16, "R11 edge and done flags", v[4:0], 5'h16);
        rd_reg(4'h1, v);
        chk(v[4] && !v[2] && !v[1], "R9 status drained", v[4:0], 5'h11);

        // R12 masking
        wr_reg(4'h3, 16'h0000); @(negedge clk);
        chk(irq == 1'b0, "R12 masked off", irq, 0);
        wr_reg(4'h3, 16'h0002); @(negedge clk);
        chk(irq == 1'b1, "R12 overflow unmasked", irq, 1);
        wr_reg(4'h3, 16'h0008); @(negedge clk);
        chk(irq == 1'b0, "R12 unset bit masked", irq, 0);

        // R10 write-one-to-clear
        wr_reg(4'h2, 16'h0002);
        rd_reg(4'h2, v); chk(v[4:0] == 5'h14, "R10 clears only bit1", v[4:0], 5'h14);
        wr_reg(4'h2, 16'hFFFF);
        rd_reg(4'h2, v); chk(v == 16'h0, "R10 clear all", v, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule